// File: doc/BRIEF.md
# Compare-and-Set Unit

This block evaluates an integer relation between two 64-bit operands and writes the outcome into a destination register value. Operand B comes either from a register or from a 5-bit unsigned immediate that is zero-extended to 64 bits. The relations are equal, not-equal, signed greater-than and signed greater-or-equal. There are no less-than or less-or-equal opcodes; the issuing logic gets those by exchanging the two sources of a greater-than or greater-or-equal request.

A separate output mode decides what is written. Boolean mode writes 0 or 1. Zero-select mode writes a third operand when the relation holds and 0 when it does not. Keep-select mode writes the third operand when the relation holds and otherwise writes back the destination's prior value, which arrives as an input. The result is registered one cycle after a valid input. An opcode outside the defined set yields 0 and raises an illegal flag.

Top module: `cmpset_unit`

## Requirements
- R1: After synchronous reset, `res_valid`, `res_data` and `res_illegal` are all 0.
- R2: A request sampled with `in_valid`=1 at clock edge N appears on the outputs after edge N, with `res_valid`=1 for exactly that one cycle. `res_valid` is 0 after any edge where `in_valid` was 0.
- R3: `res_data` and `res_illegal` update only on an edge where `in_valid`=1. Otherwise they hold their values.
- R4: Opcode 3'b000 (EQ) and 3'b001 (NE) compare `src_a` with `src_b` for equality and inequality across all 64 bits.
- R5: Opcode 3'b010 (GT) and 3'b011 (GE) compare `src_a` with `src_b` as signed 64-bit two's complement values. Sign-extended negative 32-bit values therefore order below positive ones.
- R6: Opcodes 3'b100, 3'b101 and 3'b110 are EQ, NE and GT against `imm5` zero-extended to 64 bits. `src_b` is ignored for these opcodes.
- R7: Opcode 3'b111 is illegal. It gives `res_data`=0 and `res_illegal`=1 for that result, whatever the mode. `res_illegal` is 0 for every legal opcode.
- R8: Mode 2'b00 (Boolean) writes 64'd1 when the condition holds and 64'd0 otherwise.
- R9: Mode 2'b01 (zero-select) writes `src_c` when the condition holds and 0 otherwise.
- R10: Mode 2'b10 (keep-select) writes `src_c` when the condition holds and `dst_old` otherwise. Mode 2'b11 is treated as Boolean.
- R11: Exchanging `src_a` and `src_b` on GT/GE produces signed less-than and less-or-equal results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 3 | Relation select |
| mode | input | 2 | Output mode select |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second register operand |
| imm5 | input | 5 | Unsigned immediate operand |
| src_c | input | 64 | Pass-through operand |
| dst_old | input | 64 | Prior destination value |
| res_valid | output | 1 | Result strobe |
| res_data | output | 64 | Registered result |
| res_illegal | output | 1 | Unsupported-opcode flag |

## Verification
The relations are exercised with equal operands, operands that differ only in the top bit, and operands that differ only in bit 0. The top-bit case separates signed from unsigned ordering, and the bit-0 case catches an equality test that looks at only part of the word. Sign-extended negative 32-bit values are compared against positive ones, and GT is run with operands swapped to confirm the less-than results. Immediate opcodes are driven with a `src_b` that would flip the answer, so a design that reads the wrong operand is caught. Each output mode is run with `src_c` and `dst_old` set to distinct patterns, so a mix-up between them shows in the data.

// File: rtl/cmpset_pkg.sv
package cmpset_pkg;
    localparam int XLEN = 64;
    localparam int IMMW = 5;

    typedef enum logic [2:0] {
        OP_EQ   = 3'b000,
        OP_NE   = 3'b001,
        OP_GT   = 3'b010,
        OP_GE   = 3'b011,
        OP_EQI  = 3'b100,
        OP_NEI  = 3'b101,
        OP_GTI  = 3'b110,
        OP_BAD  = 3'b111
    } cmp_op_e;

    typedef enum logic [1:0] {
        MD_BOOL = 2'b00,
        MD_ZSEL = 2'b01,
        MD_KSEL = 2'b10,
        MD_RSV  = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_NE = 2'd1,
        REL_GT = 2'd2,
        REL_GE = 2'd3
    } rel_e;

    typedef struct packed {
        rel_e rel;
        logic use_imm;
        logic illegal;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [2:0] op);
        op_dec_t d;
        d.use_imm = op[2];
        d.illegal = (op == OP_BAD);
        d.rel     = rel_e'(op[1:0]);
        return d;
    endfunction
endpackage

// File: rtl/cmpset_relation.sv
module cmpset_relation
    import cmpset_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  rel_e         rel,
    output logic         hit
);
    logic eq_w, gt_w;
    always_comb begin
        eq_w = (opa == opb);
        gt_w = ($signed(opa) > $signed(opb));
        unique case (rel)
            REL_EQ:  hit = eq_w;
            REL_NE:  hit = !eq_w;
            REL_GT:  hit = gt_w;
            default: hit = gt_w | eq_w;
        endcase
    end
endmodule

// File: rtl/cmpset_writer.sv
module cmpset_writer
    import cmpset_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         hit,
    input  logic         illegal,
    input  logic [1:0]   mode,
    input  logic [W-1:0] pass_val,
    input  logic [W-1:0] keep_val,
    output logic [W-1:0] wdata
);
    always_comb begin
        if (illegal) begin
            wdata = '0;
        end else begin
            unique case (out_mode_e'(mode))
                MD_ZSEL: wdata = hit ? pass_val : '0;
                MD_KSEL: wdata = hit ? pass_val : keep_val;
                default: wdata = {{(W-1){1'b0}}, hit};
            endcase
        end
    end
endmodule

// File: rtl/cmpset_unit.sv
module cmpset_unit
    import cmpset_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMMW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    opcode,
    input  logic [1:0]    mode,
    input  logic [W-1:0]  src_a,
    input  logic [W-1:0]  src_b,
    input  logic [IW-1:0] imm5,
    input  logic [W-1:0]  src_c,
    input  logic [W-1:0]  dst_old,
    output logic          res_valid,
    output logic [W-1:0]  res_data,
    output logic          res_illegal
);
    op_dec_t      dec;
    logic [W-1:0] opb_sel;
    logic         hit;
    logic [W-1:0] wdata;

    assign dec     = decode_op(opcode);
    assign opb_sel = dec.use_imm ? {{(W-IW){1'b0}}, imm5} : src_b;

    cmpset_relation #(.W(W)) u_rel (
        .opa(src_a), .opb(opb_sel), .rel(dec.rel), .hit(hit)
    );

    cmpset_writer #(.W(W)) u_wr (
        .hit(hit), .illegal(dec.illegal), .mode(mode),
        .pass_val(src_c), .keep_val(dst_old), .wdata(wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_illegal <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_data    <= wdata;
                res_illegal <= dec.illegal;
            end
        end
    end

    // R2: valid follows the input strobe by one cycle
    p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);
    // R3: result held without a request
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_data) && $stable(res_illegal));
    // R7: illegal opcode yields zero and flag
    p_illegal_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'b111) |=> res_illegal && res_data == '0);
    // R8: Boolean mode result is 0 or 1
    p_bool_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00) |=> res_data[W-1:1] == '0);
    // R9: zero-select yields src_c or zero
    p_zsel_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b01) |=> (res_data == $past(src_c)) || (res_data == '0));
    // R10: keep-select yields src_c or prior destination
    p_ksel_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b10 && opcode != 3'b111) |=>
            (res_data == $past(src_c)) || (res_data == $past(dst_old)));
endmodule

// File: tb/cmpset_unit_bench.sv
module cmpset_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  opcode;
    logic [1:0]  mode;
    logic [63:0] src_a, src_b, src_c, dst_old;
    logic [4:0]  imm5;
    logic        res_valid, res_illegal;
    logic [63:0] res_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    typedef struct {
        logic [63:0] data;
        logic        ill;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    cmpset_unit u_cmpset_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .mode(mode),
        .src_a(src_a), .src_b(src_b), .imm5(imm5), .src_c(src_c), .dst_old(dst_old),
        .res_valid(res_valid), .res_data(res_data), .res_illegal(res_illegal)
    );

    function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] md,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input logic [4:0] im, input logic [63:0] c,
                                          input logic [63:0] d);
        logic [63:0] bb;
        logic h;
        bb = op[2] ? {59'd0, im} : b;
        case (op)
            3'b000, 3'b100: h = (a == bb);
            3'b001, 3'b101: h = (a != bb);
            3'b010, 3'b110: h = ($signed(a) > $signed(bb));
            3'b011:         h = ($signed(a) >= $signed(bb));
            default:        return 64'd0;
        endcase
        case (md)
            2'b01:   return h ? c : 64'd0;
            2'b10:   return h ? c : d;
            default: return {63'd0, h};
        endcase
    endfunction

    task automatic send(input logic [2:0] op, input logic [1:0] md, input logic [63:0] a,
                        input logic [63:0] b, input logic [4:0] im, input logic [63:0] c,
                        input logic [63:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; opcode = op; mode = md; src_a = a; src_b = b;
        imm5 = im; src_c = c; dst_old = d;
        e.data = model(op, md, a, b, im, c, d);
        e.ill  = (op == 3'b111);
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        src_c = ~src_c; dst_old = ~dst_old;
    endtask

    // monitor: sample at negedge after a valid result
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            exp_t e;
            vectors++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected res_valid, data=%h expected none", res_data);
            end else begin
                e = q.pop_front();
                if (res_data !== e.data || res_illegal !== e.ill) begin
                    errors++;
                    $display("FAIL %s data=%h ill=%b expected data=%h ill=%b",
                             e.tag, res_data, res_illegal, e.data, e.ill);
                end
            end
        end
    end

    task automatic chk(input bit cond, input string msg);
        vectors++;
        if (!cond) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog expired, actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    localparam logic [63:0] CC = 64'hC0FF_EE00_1234_5678;
    localparam logic [63:0] DD = 64'hDEAD_BEEF_0BAD_F00D;
    localparam logic [63:0] NEG5 = 64'hFFFF_FFFF_FFFF_FFFB;

    initial begin
        rst = 1'b1; in_valid = 1'b0; opcode = '0; mode = '0;
        src_a = '0; src_b = '0; imm5 = '0; src_c = '0; dst_old = '0;
        repeat (3) @(negedge clk);
        chk(res_valid == 0 && res_data == 0 && res_illegal == 0,
            $sformatf("R1 reset v=%b d=%h i=%b expected 0", res_valid, res_data, res_illegal));
        rst = 1'b0;
        @(negedge clk);
        chk(res_valid == 0, $sformatf("R2 idle valid=%b expected 0", res_valid));

        // R4 equality
        send(3'b000, 2'b00, 64'h5, 64'h5, 5'd0, CC, DD, "R4 eq equal");
        send(3'b000, 2'b00, 64'h8000_0000_0000_0005, 64'h5, 5'd0, CC, DD, "R4 eq msb diff");
        send(3'b001, 2'b00, 64'h4, 64'h5, 5'd0, CC, DD, "R4 ne lsb diff");
        send(3'b001, 2'b00, 64'h7, 64'h7, 5'd0, CC, DD, "R4 ne equal");
        // R5 signed
        send(3'b010, 2'b00, 64'h1, NEG5, 5'd0, CC, DD, "R5 gt pos>neg");
        send(3'b010, 2'b00, 64'h8000_0000_0000_0000, 64'h1, 5'd0, CC, DD, "R5 gt min<1");
        send(3'b011, 2'b00, NEG5, NEG5, 5'd0, CC, DD, "R5 ge equal");
        send(3'b011, 2'b00, NEG5, 64'h0, 5'd0, CC, DD, "R5 ge neg");
        // R11 swap for lt/le
        send(3'b010, 2'b00, 64'h9, NEG5, 5'd0, CC, DD, "R11 lt via swap");
        send(3'b011, 2'b00, 64'h3, 64'h3, 5'd0, CC, DD, "R11 le via swap");
        // R6 immediates, src_b chosen to flip outcome
        send(3'b100, 2'b00, 64'd17, 64'd99, 5'd17, CC, DD, "R6 eqi hit");
        send(3'b101, 2'b00, 64'd31, 64'd31, 5'd30, CC, DD, "R6 nei hit");
        send(3'b110, 2'b00, NEG5, 64'h8000_0000_0000_0000, 5'd2, CC, DD, "R6 gti zero-ext");
        send(3'b110, 2'b00, 64'd32, 64'd40, 5'd31, CC, DD, "R6 gti 32>31");
        // R9 zero-select
        send(3'b000, 2'b01, 64'd1, 64'd1, 5'd0, CC, DD, "R9 zsel true");
        send(3'b000, 2'b01, 64'd1, 64'd2, 5'd0, CC, DD, "R9 zsel false");
        // R10 keep-select
        send(3'b010, 2'b10, 64'd5, 64'd2, 5'd0, CC, DD, "R10 ksel true");
        send(3'b010, 2'b10, 64'd2, 64'd5, 5'd0, CC, DD, "R10 ksel false");
        send(3'b000, 2'b11, 64'd3, 64'd3, 5'd0, CC, DD, "R10 mode3 bool");
        // R7 illegal in each mode
        send(3'b111, 2'b00, 64'd1, 64'd1, 5'd1, CC, DD, "R7 illegal bool");
        send(3'b111, 2'b10, 64'd1, 64'd1, 5'd1, CC, DD, "R7 illegal ksel");
        send(3'b001, 2'b01, 64'd1, 64'd2, 5'd0, CC, DD, "R7 legal clears flag");

        // R3 hold: change inputs with no valid
        @(negedge clk);
        begin
            logic [63:0] held;
            held = res_data;
            opcode = 3'b111; src_a = 64'd7; src_c = 64'h1; mode = 2'b01;
            repeat (3) @(negedge clk);
            chk(res_data == held && res_illegal == 0 && res_valid == 0,
                $sformatf("R3 hold data=%h ill=%b expected %h 0", res_data, res_illegal, held));
        end
        // R2 back-to-back
        @(negedge clk);
        in_valid = 1'b1; opcode = 3'b000; mode = 2'b00; src_a = 1; src_b = 1;
        q.push_back('{64'd1, 1'b0, "R2 b2b first"});
        @(negedge clk);
        src_b = 2;
        q.push_back('{64'd0, 1'b0, "R2 b2b second"});
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(q.size() == 0, $sformatf("R2 pending=%0d expected 0", q.size()));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule